// File: doc/BRIEF.md
# Reconfigurable LFSR-to-Scan Pattern Source

This block produces the serial stimulus for a scan-based self-test session. An autonomous linear-feedback shift register runs during shift cycles. Each scan-chain input is fed through a multiplexer that chooses one register bit. The choice for every chain comes from a parameter table that holds one tap entry per configuration. A configuration counter steps through the configurations in order. A one-hot decoder turns the counter value into the multiplexer selects.

A pattern counter sets how long each configuration stays active. At the start of a session it is preset with the count for the first configuration. It counts down once per applied pattern. When it expires it reloads with the next configuration's count and moves the network on.

Each pattern takes `CHAIN_LEN` shift cycles followed by one capture cycle. Two build options exist. The first applies the same fixed number of patterns in every configuration, which removes the count table. The second starts the session with a block of patterns in which the register bits feed the chains straight, with no network in the path. When the last configuration runs out, the block raises `done`, stops shifting and waits for the next start.

Top module: `rbist_src`

## Requirements
- R1: The generator state advances only in shift cycles, as next = {s[W-2:0], ^(s & FB_MASK)}. It loads SEED on reset and on an accepted start. A SEED of zero is replaced by 1, so the state is never all-zero.
- R2: Each pattern is exactly CHAIN_LEN consecutive cycles with `shift_en` high and `capture` low, followed by one cycle with `capture` high and `shift_en` low.
- R3: During a network shift cycle, `scan_in[j]` equals state bit `TAP_TABLE[(c*CHAINS+j)*TAP_W +: TAP_W]`, where c is the current configuration.
- R4: A session starts in configuration 0. Configuration c lasts `CNT_TABLE[c*CNT_W +: CNT_W]` patterns. The configuration index then rises by one on the cycle after that configuration's final capture.
- R5: The multiplexer selects are one-hot and correspond to the configuration index.
- R6: With FIXED_MODE set, every configuration lasts FIXED_CNT patterns and the count table is ignored.
- R7: With BYPASS_PATS nonzero, the session first applies that many patterns with `scan_in[j]` equal to state bit j mod W and `cfg_idx` at 0. Configuration 0 of the network follows.
- R8: After the last configuration's final capture, `done` goes high, and the total patterns applied equal BYPASS_PATS plus the sum of the per-configuration counts. `shift_en` and `capture` stay low, and `done` holds until the next start.
- R9: A start pulse while a session is running has no effect.
- R10: Reset returns the block to idle with `done`, `shift_en` and `capture` low and `cfg_idx` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a session when idle or done |
| scan_in | output | CHAINS | Serial bit for each scan chain |
| shift_en | output | 1 | High in shift cycles |
| capture | output | 1 | High in the capture cycle of each pattern |
| cfg_idx | output | idx_w(NCFG) | Current network configuration |
| done | output | 1 | Session finished; held until next start |

## Verification
The hardest situations to reach from the ports are the boundaries between phases. These include the last capture of the bypass block followed by the first network pattern, a configuration that lasts a single pattern, and a start pulse that arrives in the middle of a session. The bench runs two builds. One uses a count table containing a one-pattern configuration. The other combines fixed counts with a bypass prefix and a zero seed. The bench follows every shift cycle against its own generator model and pokes start partway through a run, so any slip at a phase boundary shows up as a wrong scan bit or a wrong strobe.

// File: rtl/rbist_pkg.sv
package rbist_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_CAPT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic capt;
        logic bypass;
    } seq_ctl_t;

    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rbist_lfsr.sv
module rbist_lfsr
    import rbist_pkg::*;
#(
    parameter int          W       = 4,
    parameter logic [W-1:0] FB_MASK = 4'b1001,
    parameter logic [W-1:0] SEED    = 4'b1011
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] SAFE_SEED = (SEED == '0) ? W'(1) : SEED;

    logic fb;
    assign fb = ^(state & FB_MASK);

    always_ff @(posedge clk) begin
        if (rst || load) state <= SAFE_SEED;
        else if (adv)    state <= {state[W-2:0], fb};
    end

    a_r1_nonzero: assert property (@(posedge clk) disable iff (rst)
        state != '0);
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(state));
endmodule

// File: rtl/rbist_dec.sv
module rbist_dec
    import rbist_pkg::*;
#(
    parameter int NCFG = 3
) (
    input  logic [idx_w(NCFG)-1:0] cfg,
    output logic [NCFG-1:0]        sel_oh
);
    for (genvar c = 0; c < NCFG; c++) begin : g_line
        assign sel_oh[c] = (int'(cfg) == c);
    end

    always_comb begin
        a_r5_onehot: assert ($onehot(sel_oh) || $isunknown(cfg));
    end
endmodule

// File: rtl/rbist_net.sv
module rbist_net
    import rbist_pkg::*;
#(
    parameter int W      = 4,
    parameter int CHAINS = 4,
    parameter int NCFG   = 3,
    parameter int TAP_W  = 2,
    parameter logic [NCFG*CHAINS*TAP_W-1:0] TAP_TABLE = '0
) (
    input  logic [W-1:0]      state,
    input  logic [NCFG-1:0]   sel_oh,
    input  logic              bypass,
    output logic [CHAINS-1:0] scan_in
);
    for (genvar j = 0; j < CHAINS; j++) begin : g_chain
        logic [NCFG-1:0] cand;
        for (genvar c = 0; c < NCFG; c++) begin : g_leg
            localparam int TAP = int'(TAP_TABLE[(c*CHAINS+j)*TAP_W +: TAP_W]);
            assign cand[c] = state[TAP % W];
        end
        assign scan_in[j] = bypass ? state[j % W] : |(cand & sel_oh);
    end
endmodule

// File: rtl/rbist_seq.sv
module rbist_seq
    import rbist_pkg::*;
#(
    parameter int NCFG        = 3,
    parameter int CHAIN_LEN   = 4,
    parameter int CNT_W       = 4,
    parameter logic [NCFG*CNT_W-1:0] CNT_TABLE = '0,
    parameter bit FIXED_MODE  = 1'b0,
    parameter int FIXED_CNT   = 1,
    parameter int BYPASS_PATS = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    output seq_ctl_t               ctl,
    output logic [idx_w(NCFG)-1:0] cfg_idx,
    output logic                   done
);
    localparam int CFG_W = idx_w(NCFG);
    localparam int SH_W  = idx_w(CHAIN_LEN);
    localparam int PC_W  = max_i(max_i(CNT_W, idx_w(BYPASS_PATS + 1)), idx_w(FIXED_CNT + 1));
    localparam logic [CFG_W-1:0] LAST = CFG_W'(NCFG - 1);

    phase_e            phase;
    logic [SH_W-1:0]   shcnt;
    logic [PC_W-1:0]   pcnt;
    logic [CFG_W-1:0]  cfg;
    logic              byp;

    function automatic logic [PC_W-1:0] count_of(input logic [CFG_W-1:0] i);
        int ii;
        ii = (int'(i) < NCFG) ? int'(i) : 0;
        if (FIXED_MODE) return PC_W'(FIXED_CNT);
        return PC_W'(CNT_TABLE[ii*CNT_W +: CNT_W]);
    endfunction

    logic accept;
    assign accept = (phase == PH_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            shcnt <= '0;
            pcnt  <= '0;
            cfg   <= '0;
            byp   <= 1'b0;
            done  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_SHIFT;
                    shcnt <= '0;
                    cfg   <= '0;
                    done  <= 1'b0;
                    if (BYPASS_PATS > 0) begin
                        byp  <= 1'b1;
                        pcnt <= PC_W'(BYPASS_PATS);
                    end else begin
                        byp  <= 1'b0;
                        pcnt <= count_of('0);
                    end
                end
                PH_SHIFT: begin
                    if (shcnt == SH_W'(CHAIN_LEN - 1)) begin
                        shcnt <= '0;
                        phase <= PH_CAPT;
                    end else begin
                        shcnt <= shcnt + 1'b1;
                    end
                end
                PH_CAPT: begin
                    phase <= PH_SHIFT;
                    if (pcnt == PC_W'(1)) begin
                        if (byp) begin
                            byp  <= 1'b0;
                            pcnt <= count_of('0);
                        end else if (cfg == LAST) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            cfg  <= cfg + 1'b1;
                            pcnt <= count_of(cfg + 1'b1);
                        end
                    end else begin
                        pcnt <= pcnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign ctl.load   = accept;
    assign ctl.shift  = (phase == PH_SHIFT);
    assign ctl.capt   = (phase == PH_CAPT);
    assign ctl.bypass = byp;
    assign cfg_idx    = cfg;

    a_r4_cfg_bound: assert property (@(posedge clk) disable iff (rst)
        int'(cfg) < NCFG);
    a_r4_cfg_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAPT && pcnt == PC_W'(1) && !byp && cfg != LAST) |=> cfg == $past(cfg) + 1'b1);
    a_r4_pcnt_live: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> pcnt != '0);
    a_r2_single_capture: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAPT) |=> phase != PH_CAPT);
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_IDLE));
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SHIFT && shcnt != SH_W'(CHAIN_LEN - 1)) |=> phase == PH_SHIFT && shcnt == $past(shcnt) + 1'b1);
endmodule

// File: rtl/rbist_src.sv
module rbist_src
    import rbist_pkg::*;
#(
    parameter int W           = 4,
    parameter logic [W-1:0] FB_MASK = 4'b1001,
    parameter logic [W-1:0] SEED    = 4'b1011,
    parameter int CHAINS      = 4,
    parameter int CHAIN_LEN   = 4,
    parameter int NCFG        = 3,
    parameter int CNT_W       = 4,
    parameter logic [NCFG*CHAINS*idx_w(W)-1:0] TAP_TABLE =
        {2'd3, 2'd0, 2'd0, 2'd2,  2'd1, 2'd3, 2'd2, 2'd0,  2'd0, 2'd1, 2'd1, 2'd3},
    parameter logic [NCFG*CNT_W-1:0] CNT_TABLE = {4'd2, 4'd1, 4'd3},
    parameter bit FIXED_MODE  = 1'b0,
    parameter int FIXED_CNT   = 1,
    parameter int BYPASS_PATS = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    output logic [CHAINS-1:0]      scan_in,
    output logic                   shift_en,
    output logic                   capture,
    output logic [idx_w(NCFG)-1:0] cfg_idx,
    output logic                   done
);
    localparam int TAP_W = idx_w(W);

    seq_ctl_t         ctl;
    logic [W-1:0]     state;
    logic [NCFG-1:0]  sel_oh;

    rbist_seq #(
        .NCFG(NCFG), .CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W), .CNT_TABLE(CNT_TABLE),
        .FIXED_MODE(FIXED_MODE), .FIXED_CNT(FIXED_CNT), .BYPASS_PATS(BYPASS_PATS)
    ) seq_i (
        .clk(clk), .rst(rst), .start(start),
        .ctl(ctl), .cfg_idx(cfg_idx), .done(done)
    );

    rbist_lfsr #(.W(W), .FB_MASK(FB_MASK), .SEED(SEED)) lfsr_i (
        .clk(clk), .rst(rst), .load(ctl.load), .adv(ctl.shift), .state(state)
    );

    rbist_dec #(.NCFG(NCFG)) dec_i (.cfg(cfg_idx), .sel_oh(sel_oh));

    rbist_net #(
        .W(W), .CHAINS(CHAINS), .NCFG(NCFG), .TAP_W(TAP_W), .TAP_TABLE(TAP_TABLE)
    ) net_i (
        .state(state), .sel_oh(sel_oh), .bypass(ctl.bypass), .scan_in(scan_in)
    );

    assign shift_en = ctl.shift;
    assign capture  = ctl.capt;
endmodule

// File: tb/rbist_src_tb.sv
module rbist_src_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int L = 4;
    localparam logic [23:0] TAPS =
        {2'd3, 2'd0, 2'd0, 2'd2,  2'd1, 2'd3, 2'd2, 2'd0,  2'd0, 2'd1, 2'd1, 2'd3};
    // Expected configuration per pattern (count table 3,1,2) and for the bypass build
    localparam int EXP_A [6] = '{0, 0, 0, 1, 2, 2};
    localparam int EXP_B [5] = '{0, 0, 0, 1, 2};
    localparam bit BYP_B [5] = '{1, 1, 0, 0, 0};

    logic clk = 1'b0, rst = 1'b1, start_a = 1'b0, start_b = 1'b0;
    logic [3:0] scan_a, scan_b;
    logic sh_a, sh_b, cp_a, cp_b, dn_a, dn_b;
    logic [1:0] cf_a, cf_b;
    int n_chk = 0, n_bad = 0;
    bit use_b = 1'b0;
    logic [3:0] s_scan;
    logic s_sh, s_cp, s_dn;
    logic [1:0] s_cf;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbist_src dut_i (.clk(clk), .rst(rst), .start(start_a), .scan_in(scan_a),
        .shift_en(sh_a), .capture(cp_a), .cfg_idx(cf_a), .done(dn_a));

    rbist_src #(.SEED(4'b0000), .FIXED_MODE(1'b1), .FIXED_CNT(1), .BYPASS_PATS(2)) dut_b_i (
        .clk(clk), .rst(rst), .start(start_b), .scan_in(scan_b),
        .shift_en(sh_b), .capture(cp_b), .cfg_idx(cf_b), .done(dn_b));

    assign s_scan = use_b ? scan_b : scan_a;
    assign s_sh   = use_b ? sh_b : sh_a;
    assign s_cp   = use_b ? cp_b : cp_a;
    assign s_dn   = use_b ? dn_b : dn_a;
    assign s_cf   = use_b ? cf_b : cf_a;

    function automatic logic [3:0] nxt(input logic [3:0] s);
        return {s[2:0], s[3] ^ s[0]};
    endfunction

    function automatic int tap_of(input int c, input int j);
        return int'(TAPS[(c*4+j)*2 +: 2]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_session(input bit b, input bit poke);
        int np;
        logic [3:0] m;
        np = b ? 5 : 6;
        m  = b ? 4'h1 : 4'hB;          // R1: zero seed becomes 1
        use_b = b;
        @(negedge clk);
        if (b) start_b = 1'b1; else start_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_a = 1'b0; start_b = 1'b0;
        for (int p = 0; p < np; p++) begin
            int  ec;
            bit  eb;
            ec = b ? EXP_B[p] : EXP_A[p];
            eb = b ? BYP_B[p] : 1'b0;
            for (int s = 0; s < L; s++) begin
                logic [3:0] es;
                for (int j = 0; j < 4; j++) es[j] = eb ? m[j] : m[tap_of(ec, j)];
                chk(eb ? "R7 bypass scan" : "R3 scan", s_scan, es);
                chk("R2 shift_en", s_sh, 1'b1);
                chk("R4 cfg_idx", s_cf, ec);
                if (poke && p == 1 && s == 1) start_a = 1'b1;   // R9 stray start
                @(posedge clk);
                m = nxt(m);                                      // R1
                @(negedge clk);
                start_a = 1'b0;
            end
            chk("R2 capture", s_cp, 1'b1);
            chk("R2 no shift in capture", s_sh, 1'b0);
            chk(b ? "R6 cfg_idx capt" : "R4 cfg_idx capt", s_cf, ec);
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8 done", s_dn, 1'b1);
        chk("R8 quiet shift", s_sh, 1'b0);
        chk("R8 quiet capture", s_cp, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 done", dn_a, 1'b0);
        chk("R10 shift", sh_a, 1'b0);
        chk("R10 capture", cp_a, 1'b0);
        chk("R10 cfg", cf_a, 2'd0);

        run_session(1'b0, 1'b1);   // R3 R4 R8 R9 with a mid-run start
        repeat (5) begin
            @(negedge clk);
            chk("R8 done held", dn_a, 1'b1);
            chk("R8 no shift while done", sh_a, 1'b0);
        end
        run_session(1'b0, 1'b0);   // restart reloads seed, R1
        run_session(1'b1, 1'b0);   // R6 R7 with zero seed

        // R10: reset in mid-session
        @(negedge clk); start_a = 1'b1;
        @(negedge clk); start_a = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R10 mid reset shift", sh_a, 1'b0);
        chk("R10 mid reset capture", cp_a, 1'b0);
        chk("R10 mid reset cfg", cf_a, 2'd0);
        chk("R10 mid reset done", dn_a, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 stays idle", sh_a, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule